// File: doc/BRIEF.md
# Two-Bank Register File with 16-bit Pair Access

This block is the operand storage of an 8-bit accumulator-style processor core. It keeps eight byte-wide registers in each of two banks: bank 0 serves normal code and bank 1 serves interrupt handlers. A handler therefore finds a private register set and nothing has to be saved to the stack on entry. Register 0 plays the accumulator role for the surrounding datapath. Registers 1 to 7 are general purpose. Instruction decode and the ALU live outside this block.

Each cycle the block offers two independent byte reads and one byte write. It also offers a 16-bit read of a register pair, formed from a register as the low byte and the next-higher register as the high byte. This pair is used for index addressing. A pair-increment request adds one to the selected pair in place and reports the carry out of bit 15 to the status logic. All pins are plain per-cycle control and data with no handshake: a read is valid in the cycle its index is presented, and a write or an increment takes effect at the next rising clock edge. The block never stalls.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low, every register of both banks is cleared to 0x00 and `bank_active` is 0. After reset, reading any index in either bank returns 0x00 until that register is written.
- R2: At each rising edge `bank_active` takes the value `irq_active` had before the edge. Every read, write and increment uses the bank `bank_active` names (0 for normal code, 1 for interrupt handlers). The other bank keeps its contents.
- R3: When `wr_en` is high at a rising edge, `wr_data` is stored into register `wr_idx` of the active bank. From the next cycle on, reads of that register return the stored value, except in the conflict case of R9.
- R4: Writes are visible in the same cycle. When an accepted write targets a register that a read port or either pair byte selects, that output returns `wr_data` rather than the stored byte.
- R5: `pair_data` equals {R[(pair_idx+1) mod 8], R[pair_idx]}, with R[pair_idx] in bits 7:0.
- R6: When `pair_inc` is high at a rising edge, the selected pair is replaced by `pair_data`+1 modulo 2^16. The low byte goes back to R[pair_idx] and the high byte to R[(pair_idx+1) mod 8].
- R7: `pair_carry` is 1 exactly when `pair_inc` is high and `pair_data` is 0xFFFF; otherwise it is 0. The increment from 0xFFFF leaves the pair at 0x0000.
- R8: With `pair_idx` = 7 the pair wraps: bits 15:8 come from R0 and bits 7:0 from R7, and an increment writes R0 and R7.
- R9: If `pair_inc` and `wr_en` are both high and `wr_idx` names one of the two pair registers, the increment wins: the write is dropped and no bypass occurs. A write to any other register proceeds in the same cycle.
- R10: The two read ports are independent. Any two indices, including equal ones, return their registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears both banks |
| irq_active | input | 1 | Interrupt-servicing state; selects bank 1 from the next cycle |
| rd_a_idx | input | 3 | Read port A register index |
| rd_b_idx | input | 3 | Read port B register index |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_data | input | 8 | Write data |
| pair_idx | input | 3 | Low register of the pair |
| pair_inc | input | 1 | Increment the selected pair at the next edge |
| rd_a_data | output | 8 | Read port A data |
| rd_b_data | output | 8 | Read port B data |
| pair_data | output | 16 | Pair value, high register in bits 15:8 |
| pair_carry | output | 1 | Carry out of the pair increment |
| bank_active | output | 1 | Bank currently in use |

## Verification
The assertions assume that every input is a known value at every rising edge once reset is released. They also assume that reset is held across at least one edge, so that both banks start cleared. They place no limit on index combinations, so conflicting write and increment requests are legal. The stimulus changes inputs only on the falling edge. It draws indices, data and requests at random under a fixed seed, and weights the write index toward the pair registers so that the conflict of R9 occurs often. It also toggles `irq_active` so that both banks fill. Directed steps cover the wrap pair, the 0xFFFF carry and bank isolation.

// File: rtl/brf_pkg.sv
package brf_pkg;
  parameter int DATA_W    = 8;
  parameter int NUM_REGS  = 8;
  parameter int NUM_BANKS = 2;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int PAIR_W   = 2 * DATA_W;
  localparam int NUM_RDP  = 4;   // port A, port B, pair low, pair high

  typedef logic [DATA_W-1:0]                 byte_t;
  typedef logic [IDX_W-1:0]                  idx_t;
  typedef logic [PAIR_W-1:0]                 pair_t;
  typedef logic [NUM_REGS-1:0][DATA_W-1:0]   row_t;
endpackage

// File: rtl/brf_bank_ctrl.sv
module brf_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_active,
  output logic bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= 1'b0;
    else        bank_q <= irq_active;
  end

  // R2: the bank follows the interrupt state one edge later
  p_bank_follows_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bank_q == $past(irq_active)));
endmodule

// File: rtl/brf_storage.sv
module brf_storage
  import brf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bank,
  input  logic  wr_eff,
  input  idx_t  wr_idx,
  input  byte_t wr_data,
  input  logic  inc_en,
  input  idx_t  lo_idx,
  input  idx_t  hi_idx,
  input  pair_t inc_value,
  output row_t  cur_row
);
  byte_t mem [NUM_BANKS][NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int r = 0; r < NUM_REGS; r++)
          mem[b][r] <= '0;
    end else begin
      if (wr_eff)
        mem[bank][wr_idx] <= wr_data;
      if (inc_en) begin
        mem[bank][lo_idx] <= inc_value[DATA_W-1:0];
        mem[bank][hi_idx] <= inc_value[PAIR_W-1:DATA_W];
      end
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    assign cur_row[r] = mem[bank][r];
  end

  // R3: an accepted write lands in the addressed register
  p_write_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eff |=> (mem[$past(bank)][$past(wr_idx)] == $past(wr_data)));

  // R6: an increment leaves the old pair value plus one
  p_pair_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> ({mem[$past(bank)][$past(hi_idx)], mem[$past(bank)][$past(lo_idx)]}
                == PAIR_W'($past({cur_row[hi_idx], cur_row[lo_idx]}) + 1)));

  // R9: a write never shares an edge with an increment of the same register
  p_no_shared_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eff && inc_en) |-> ((wr_idx != lo_idx) && (wr_idx != hi_idx)));
endmodule

// File: rtl/brf_read_port.sv
module brf_read_port
  import brf_pkg::*;
(
  input  row_t  row,
  input  idx_t  rd_idx,
  input  logic  byp_en,
  input  idx_t  byp_idx,
  input  byte_t byp_data,
  output byte_t rd_data
);
  always_comb begin
    if (byp_en && (byp_idx == rd_idx)) rd_data = byp_data;
    else                               rd_data = row[rd_idx];
  end
endmodule

// File: rtl/brf_pair_unit.sv
module brf_pair_unit
  import brf_pkg::*;
(
  input  idx_t  pair_idx,
  input  byte_t lo_byte,
  input  byte_t hi_byte,
  input  logic  inc_req,
  output idx_t  hi_idx,
  output pair_t pair_val,
  output pair_t inc_val,
  output logic  carry
);
  logic [PAIR_W:0] sum;

  // index arithmetic wraps modulo the register count
  assign hi_idx   = idx_t'((int'(pair_idx) + 1) % NUM_REGS);
  assign pair_val = {hi_byte, lo_byte};
  assign sum      = {1'b0, pair_val} + {{PAIR_W{1'b0}}, 1'b1};
  assign inc_val  = sum[PAIR_W-1:0];
  assign carry    = inc_req & sum[PAIR_W];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq_active,
  input  logic [IDX_W-1:0]     rd_a_idx,
  input  logic [IDX_W-1:0]     rd_b_idx,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]     pair_idx,
  input  logic                 pair_inc,
  output logic [DATA_W-1:0]    rd_a_data,
  output logic [DATA_W-1:0]    rd_b_data,
  output logic [PAIR_W-1:0]    pair_data,
  output logic                 pair_carry,
  output logic                 bank_active
);
  logic  bank_q;
  idx_t  hi_idx;
  logic  wr_hits_pair;
  logic  wr_eff;
  row_t  cur_row;
  pair_t inc_val;
  idx_t  rd_idx  [NUM_RDP];
  byte_t rd_data [NUM_RDP];

  brf_bank_ctrl u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_active (irq_active),
    .bank_q     (bank_q)
  );

  // increment owns both pair registers when it collides with the write port
  assign wr_hits_pair = (wr_idx == pair_idx) || (wr_idx == hi_idx);
  assign wr_eff       = wr_en && !(pair_inc && wr_hits_pair);

  brf_storage u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank      (bank_q),
    .wr_eff    (wr_eff),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .inc_en    (pair_inc),
    .lo_idx    (pair_idx),
    .hi_idx    (hi_idx),
    .inc_value (inc_val),
    .cur_row   (cur_row)
  );

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;
  assign rd_idx[2] = pair_idx;
  assign rd_idx[3] = hi_idx;

  for (genvar p = 0; p < NUM_RDP; p++) begin : g_rdp
    brf_read_port u_rdp (
      .row      (cur_row),
      .rd_idx   (rd_idx[p]),
      .byp_en   (wr_eff),
      .byp_idx  (wr_idx),
      .byp_data (wr_data),
      .rd_data  (rd_data[p])
    );
  end

  brf_pair_unit u_pair (
    .pair_idx (pair_idx),
    .lo_byte  (rd_data[2]),
    .hi_byte  (rd_data[3]),
    .inc_req  (pair_inc),
    .hi_idx   (hi_idx),
    .pair_val (pair_data),
    .inc_val  (inc_val),
    .carry    (pair_carry)
  );

  assign rd_a_data   = rd_data[0];
  assign rd_b_data   = rd_data[1];
  assign bank_active = bank_q;

  // R4: same-cycle write is seen on both read ports
  p_bypass_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eff && (wr_idx == rd_a_idx)) |-> (rd_a_data == wr_data));
  p_bypass_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eff && (wr_idx == rd_b_idx)) |-> (rd_b_data == wr_data));

  // R7: carry only on an increment of an all-ones pair
  p_carry_all_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_carry |-> (pair_inc && (pair_data == {PAIR_W{1'b1}})));
  p_carry_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_carry && $stable(bank_q) && !irq_active && !bank_q) |=> (cur_row[$past(pair_idx)] == '0));

  // R10: equal indices on both ports give equal data
  p_ports_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/100ps
module banked_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_active;
  logic [2:0] rd_a_idx, rd_b_idx, wr_idx, pair_idx;
  logic       wr_en, pair_inc;
  logic [7:0] wr_data;
  logic [7:0] rd_a_data, rd_b_data;
  logic [15:0] pair_data;
  logic       pair_carry, bank_active;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m_mem [2][8];
  logic       m_bank;

  always #2.5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .irq_active(irq_active),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pair_idx(pair_idx), .pair_inc(pair_inc),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .pair_data(pair_data), .pair_carry(pair_carry),
    .bank_active(bank_active)
  );

  function automatic logic [2:0] f_hi(input logic [2:0] n);
    return 3'(n + 3'd1);
  endfunction

  function automatic bit f_wr_ok();
    return wr_en && !(pair_inc && (wr_idx == pair_idx || wr_idx == f_hi(pair_idx)));
  endfunction

  function automatic logic [7:0] f_rd(input logic [2:0] i);
    if (f_wr_ok() && wr_idx == i) return wr_data;
    return m_mem[m_bank][i];
  endfunction

  function automatic logic [15:0] f_pair();
    return {f_rd(f_hi(pair_idx)), f_rd(pair_idx)};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive on falling edge, check outputs, then advance the model at the rising edge
  task automatic step(input logic irq, input logic [2:0] ra, input logic [2:0] rb,
                      input logic we, input logic [2:0] wi, input logic [7:0] wd,
                      input logic [2:0] pi, input logic inc, input string tag);
    logic [15:0] p;
    @(negedge clk);
    irq_active = irq; rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd; pair_idx = pi; pair_inc = inc;
    #1;
    chk("R2", "bank_active", {15'd0, bank_active}, {15'd0, m_bank});
    chk((f_wr_ok() && wi == ra) ? "R4" : "R10", "rd_a_data", {8'd0, rd_a_data}, {8'd0, f_rd(ra)});
    chk((f_wr_ok() && wi == rb) ? "R4" : "R3", "rd_b_data", {8'd0, rd_b_data}, {8'd0, f_rd(rb)});
    chk(tag, "pair_data", pair_data, f_pair());
    chk("R7", "pair_carry", {15'd0, pair_carry}, {15'd0, (inc && f_pair() == 16'hFFFF)});
    p = f_pair() + 16'd1;
    @(posedge clk);
    if (f_wr_ok()) m_mem[m_bank][wi] = wd;
    if (inc) begin
      m_mem[m_bank][pi]       = p[7:0];
      m_mem[m_bank][f_hi(pi)] = p[15:8];
    end
    m_bank = irq;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int b = 0; b < 2; b++) for (int r = 0; r < 8; r++) m_mem[b][r] = 8'h00;
    m_bank = 1'b0;
    rst_n = 1'b0; irq_active = 0; rd_a_idx = 0; rd_b_idx = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0; pair_idx = 0; pair_inc = 0;
    // preload garbage write attempts during reset: must be ignored (R1)
    repeat (3) begin
      @(negedge clk); wr_en = 1; wr_idx = 3'd5; wr_data = 8'hA5;
    end
    @(negedge clk); wr_en = 0; rst_n = 1'b1;
    // R1: both banks read zero after reset
    for (int r = 0; r < 8; r++) step(0, 3'(r), 3'(7 - r), 0, 0, 0, 3'(r), 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    for (int r = 0; r < 8; r++) step(1, 3'(r), 3'(r), 0, 0, 0, 3'(r), 0, "R1");
    // R2: fill bank 1, switch to bank 0, confirm isolation
    step(1, 0, 0, 1, 3'd4, 8'h4C, 3'd4, 0, "R4");
    step(0, 3'd4, 3'd4, 0, 0, 0, 3'd4, 0, "R3");
    step(0, 3'd4, 3'd4, 0, 0, 0, 3'd4, 0, "R2");
    // R8: wrap pair built from R7 and R0
    step(0, 0, 0, 1, 3'd0, 8'h12, 3'd7, 0, "R4");
    step(0, 0, 7, 1, 3'd7, 8'h34, 3'd7, 0, "R4");
    step(0, 0, 7, 0, 0, 0, 3'd7, 1, "R8");
    step(0, 0, 7, 0, 0, 0, 3'd7, 0, "R8");
    // R7: all-ones pair increments to zero with carry
    step(0, 2, 3, 1, 3'd2, 8'hFF, 3'd2, 0, "R5");
    step(0, 2, 3, 1, 3'd3, 8'hFF, 3'd2, 0, "R5");
    step(0, 2, 3, 0, 0, 0, 3'd2, 1, "R7");
    step(0, 2, 3, 0, 0, 0, 3'd2, 0, "R6");
    // R9: conflicting write dropped, unrelated write accepted
    step(0, 2, 3, 1, 3'd3, 8'h99, 3'd2, 1, "R9");
    step(0, 2, 6, 1, 3'd6, 8'h66, 3'd2, 1, "R9");
    step(0, 2, 6, 0, 0, 0, 3'd2, 0, "R9");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] pi, wi;
      pi = 3'($urandom_range(0, 7));
      wi = ($urandom_range(0, 3) == 0) ? 3'(pi + 3'($urandom_range(0, 1))) : 3'($urandom_range(0, 7));
      step(($urandom_range(0, 7) == 0) ? ~m_bank : m_bank,
           3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), wi, 8'($urandom_range(0, 255)),
           pi, ($urandom_range(0, 3) == 0), "R6");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule